// File: doc/BRIEF.md
# Triple-DES Unit Host Register Front-End

This block sits between a 64-bit host register bus and a DES/triple-DES cipher datapath. It decodes host accesses into a final-block trigger, a chaining-vector register, three write-only key registers, a key-size register and an interrupt status register. It also decodes a wide address window where every address reaches the same FIFO end. Writes into the window fill an 8-deep input FIFO that the datapath drains. Reads from the window take words from an 8-deep output FIFO that the datapath fills.

The block stores the keys. Every write of key 1 is copied into key 3, so two-key triple DES needs no third write. When three-key operation is wanted, writing key 3 last replaces that copy. Illegal accesses, FIFO overflow and FIFO underflow each set a sticky status bit, and the OR of the status bits drives an interrupt line. Towards the datapath the block exports the keys, the key size and the chaining vector. It takes chaining-vector updates back from the datapath. It uses a pending-final-block flag and a completion pulse to produce the done status.

Top module: `cipher_regfront`

## Requirements
- R1: A host write to address 0 (any data) raises `last_block` from the next cycle. A `dp_last_done` pulse while `last_block` is high sets status bit 0 (done) and drops `last_block`. A `dp_last_done` pulse while `last_block` is low changes nothing.
- R2: Address 1 (chaining vector) reads back the last value written. A `dp_iv_wr` pulse replaces it with `dp_iv_word`, and `iv_o` always shows the current value.
- R3: A host read of address 1 while `dp_busy` is high returns zero, sets status bit 4 and leaves the chaining vector unchanged.
- R4: A host write to address 2 (key 1) loads the value into both `key1_o` and `key3_o`.
- R5: With key size 16 or 24, a write to address 3 loads `key2_o` and a write to address 4 loads `key3_o`. A later key-3 write overrides the mirrored copy.
- R6: While the key-size register (address 5, bits 7:0, reset 0) holds 8, host writes to addresses 3 and 4 are ignored.
- R7: A host read of address 0, 2, 3, 4 or 7 returns zero and sets status bit 3 (address error).
- R8: Any host write with address bit 5 set pushes the word into the input FIFO, seen at `dp_in_word` and `in_level`. Any host read with address bit 5 set pops the output FIFO in first-in order, and the word appears on `host_rdata` one cycle later.
- R9: A host push into a full (8-entry) input FIFO drops the word, keeps `in_level` at 8 and sets status bit 1.
- R10: A host pop from an empty output FIFO returns zero and sets status bit 2.
- R11: Status bits (read at address 6) are sticky. Writing 1 to a bit at address 6 clears only that bit, and `irq` is high whenever any status bit is set.
- R12: After reset, every output, key, level, status bit and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W (6) | Host word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, valid the cycle after the read |
| irq | output | 1 | OR of all status bits |
| dp_busy | input | 1 | Datapath is processing a block |
| dp_in_pop | input | 1 | Datapath takes the input FIFO head |
| dp_in_word | output | 64 | Input FIFO head word |
| in_level | output | 4 | Input FIFO occupancy |
| dp_out_push | input | 1 | Datapath stores a result word |
| dp_out_word | input | 64 | Result word |
| out_level | output | 4 | Output FIFO occupancy |
| dp_iv_wr | input | 1 | Datapath updates the chaining vector |
| dp_iv_word | input | 64 | New chaining vector |
| dp_last_done | input | 1 | Datapath finished the final block |
| last_block | output | 1 | Final block of the message has been signalled |
| key_size_o | output | 8 | Key size in bytes |
| key1_o | output | 64 | Key 1 |
| key2_o | output | 64 | Key 2 |
| key3_o | output | 64 | Key 3 |
| iv_o | output | 64 | Current chaining vector |

## Verification
Host writes, datapath pulses and status changes take effect at the clock edge that samples them, so the key, vector, flag, level and status outputs are due one cycle after the stimulus. Read data is registered and appears on `host_rdata` in the cycle after the read strobe. The input FIFO head shows on `dp_in_word` in the cycle after the push edge. Each scenario task drives its stimulus just after a falling edge and samples at the following falling edge, half a period after the edge where the result becomes due.

// File: rtl/cipher_regfront_pkg.sv
package cipher_regfront_pkg;

    localparam int WORD_W = 64;
    localparam int NUM_ST = 5;

    // status bit positions
    localparam int ST_DONE   = 0;
    localparam int ST_OVF    = 1;
    localparam int ST_UNF    = 2;
    localparam int ST_ADDR   = 3;
    localparam int ST_BUSYRD = 4;

    localparam logic [7:0] KSIZE_SINGLE = 8'd8;

    typedef enum logic [2:0] {
        SEL_GO    = 3'd0,
        SEL_IV    = 3'd1,
        SEL_KEY1  = 3'd2,
        SEL_KEY2  = 3'd3,
        SEL_KEY3  = 3'd4,
        SEL_KSIZE = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/cipher_regfront_fifo.sv
module cipher_regfront_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] level
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wptr;
        logic [PTR_W-1:0]        rptr;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wptr] = push_data;
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rptr];
    assign level = st_q.cnt;

    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == CNT_W'(DEPTH)) |=> level == CNT_W'(DEPTH));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> level == '0);

endmodule

// File: rtl/cipher_regfront_keys.sv
module cipher_regfront_keys #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_k1,
    input  logic         wr_k2,
    input  logic         wr_k3,
    input  logic [W-1:0] wdata,
    input  logic         single_des,
    output logic [W-1:0] key1_o,
    output logic [W-1:0] key2_o,
    output logic [W-1:0] key3_o
);

    typedef struct packed {
        logic [W-1:0] k1;
        logic [W-1:0] k2;
        logic [W-1:0] k3;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_k1) begin
            st_d.k1 = wdata;
            st_d.k3 = wdata;          // mirror for two-key operation
        end
        if (wr_k2 && !single_des) st_d.k2 = wdata;
        if (wr_k3 && !single_des) st_d.k3 = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key1_o = st_q.k1;
    assign key2_o = st_q.k2;
    assign key3_o = st_q.k3;

    assert_key1_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_k1 && !wr_k3) |=> (key3_o == $past(wdata) && key1_o == $past(wdata)));

    assert_single_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_des && !wr_k1) |=> ($stable(key2_o) && $stable(key3_o)));

endmodule

// File: rtl/cipher_regfront_status.sv
module cipher_regfront_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] bits;
        logic         irq;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a new event wins over a simultaneous clear
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
        st_d.irq  = |st_d.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.bits;
    assign irq    = st_q.irq;

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_o) & ~$past(clr_i)) & ~stat_o) == '0));

    assert_irq_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_o != '0));

endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
    import cipher_regfront_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              irq,
    input  logic              dp_busy,
    input  logic              dp_in_pop,
    output logic [63:0]       dp_in_word,
    output logic [CNT_W-1:0]  in_level,
    input  logic              dp_out_push,
    input  logic [63:0]       dp_out_word,
    output logic [CNT_W-1:0]  out_level,
    input  logic              dp_iv_wr,
    input  logic [63:0]       dp_iv_word,
    input  logic              dp_last_done,
    output logic              last_block,
    output logic [7:0]        key_size_o,
    output logic [63:0]       key1_o,
    output logic [63:0]       key2_o,
    output logic [63:0]       key3_o,
    output logic [63:0]       iv_o
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] iv;
        logic [7:0]        ksize;
        logic              go_pend;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              in_win, low_ok;
    reg_sel_e          sel;
    logic              wr_reg, rd_reg;
    logic              in_full, out_empty;
    logic              host_pop, host_push;
    logic [NUM_ST-1:0] st_set, st_clr, stat;
    logic [63:0]       out_head;
    logic              wr_k1, wr_k2, wr_k3;

    // address decode: upper half is the FIFO window, low registers need zero middle bits
    assign in_win = host_addr[ADDR_W-1];
    assign low_ok = (host_addr[ADDR_W-2:3] == '0);
    assign sel    = low_ok ? reg_sel_e'(host_addr[2:0]) : SEL_NONE;
    assign wr_reg = host_wr && !in_win;
    assign rd_reg = host_rd && !in_win;

    assign in_full   = (in_level == CNT_W'(FIFO_DEPTH));
    assign out_empty = (out_level == '0);
    assign host_push = host_wr && in_win;
    assign host_pop  = host_rd && in_win;

    assign wr_k1 = wr_reg && sel == SEL_KEY1;
    assign wr_k2 = wr_reg && sel == SEL_KEY2;
    assign wr_k3 = wr_reg && sel == SEL_KEY3;

    always_comb begin
        st_d   = st_q;
        st_set = '0;
        st_clr = '0;

        // chaining vector: host write has priority over datapath update
        if (dp_iv_wr) st_d.iv = dp_iv_word;
        if (wr_reg && sel == SEL_IV) st_d.iv = host_wdata;
        if (wr_reg && sel == SEL_KSIZE) st_d.ksize = host_wdata[7:0];
        if (wr_reg && sel == SEL_STAT) st_clr = host_wdata[NUM_ST-1:0];

        // final-block handshake
        if (dp_last_done && st_q.go_pend) begin
            st_d.go_pend   = 1'b0;
            st_set[ST_DONE] = 1'b1;
        end
        if (wr_reg && sel == SEL_GO) st_d.go_pend = 1'b1;

        if (host_push && in_full) st_set[ST_OVF] = 1'b1;

        // read data path
        if (host_rd) st_d.rdata = '0;
        if (host_pop) begin
            if (out_empty) st_set[ST_UNF] = 1'b1;
            else           st_d.rdata = out_head;
        end
        if (rd_reg) begin
            case (sel)
                SEL_IV: begin
                    if (dp_busy) st_set[ST_BUSYRD] = 1'b1;
                    else         st_d.rdata = st_q.iv;
                end
                SEL_KSIZE: st_d.rdata = {56'd0, st_q.ksize};
                SEL_STAT:  st_d.rdata = {{(WORD_W - NUM_ST){1'b0}}, stat};
                default:   st_set[ST_ADDR] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign iv_o       = st_q.iv;
    assign key_size_o = st_q.ksize;
    assign last_block = st_q.go_pend;

    cipher_regfront_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_in_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_push),
        .push_data (host_wdata),
        .pop       (dp_in_pop),
        .head      (dp_in_word),
        .level     (in_level)
    );

    cipher_regfront_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_out_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dp_out_push),
        .push_data (dp_out_word),
        .pop       (host_pop),
        .head      (out_head),
        .level     (out_level)
    );

    cipher_regfront_keys #(.W(WORD_W)) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_k1      (wr_k1),
        .wr_k2      (wr_k2),
        .wr_k3      (wr_k3),
        .wdata      (host_wdata),
        .single_des (st_q.ksize == KSIZE_SINGLE),
        .key1_o     (key1_o),
        .key2_o     (key2_o),
        .key3_o     (key3_o)
    );

    cipher_regfront_status #(.N(NUM_ST)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .stat_o (stat),
        .irq    (irq)
    );

    assert_go_sets_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && sel == SEL_GO) |=> last_block);

    assert_done_clears_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (last_block && dp_last_done && !(wr_reg && sel == SEL_GO)) |=> (!last_block && stat[ST_DONE]));

    assert_busy_iv_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg && sel == SEL_IV && dp_busy) |=> (host_rdata == '0 && stat[ST_BUSYRD]));

    assert_key_read_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg && (sel == SEL_KEY1 || sel == SEL_KEY2 || sel == SEL_KEY3 || sel == SEL_GO))
        |=> (host_rdata == '0 && stat[ST_ADDR]));

    assert_underflow_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && out_empty) |=> (host_rdata == '0 && stat[ST_UNF]));

endmodule

// File: tb/cipher_regfront_bench.sv
`timescale 1ns/1ps
module cipher_regfront_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0;
    logic [5:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        irq;
    logic        dp_busy = 0, dp_in_pop = 0, dp_out_push = 0, dp_iv_wr = 0, dp_last_done = 0;
    logic [63:0] dp_out_word = '0, dp_iv_word = '0;
    logic [63:0] dp_in_word, key1_o, key2_o, key3_o, iv_o;
    logic [3:0]  in_level, out_level;
    logic        last_block;
    logic [7:0]  key_size_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cipher_regfront u_cipher_regfront (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .dp_busy(dp_busy), .dp_in_pop(dp_in_pop), .dp_in_word(dp_in_word),
        .in_level(in_level), .dp_out_push(dp_out_push), .dp_out_word(dp_out_word),
        .out_level(out_level), .dp_iv_wr(dp_iv_wr), .dp_iv_word(dp_iv_word),
        .dp_last_done(dp_last_done), .last_block(last_block), .key_size_o(key_size_o),
        .key1_o(key1_o), .key2_o(key2_o), .key3_o(key3_o), .iv_o(iv_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic clear_status();
        wr(6'd6, 64'h1F);
    endtask

    task automatic t_reset();
        chk("R12 rdata", host_rdata, 0);
        chk("R12 irq", {63'd0, irq}, 0);
        chk("R12 last_block", {63'd0, last_block}, 0);
        chk("R12 levels", {56'd0, in_level, out_level}, 0);
        chk("R12 keys", key1_o | key2_o | key3_o | iv_o, 0);
        chk("R12 ksize", {56'd0, key_size_o}, 0);
    endtask

    task automatic t_go_done();
        logic [63:0] d;
        wr(6'd0, 64'hDEAD_BEEF);
        chk("R1 last_block after go", {63'd0, last_block}, 1);
        rd(6'd0, d);
        chk("R7 go read data", d, 0);
        rd(6'd6, d);
        chk("R7 addr error bit", d, 64'h08);
        wr(6'd6, 64'h08);
        rd(6'd6, d);
        chk("R11 w1c clear", d, 0);
        @(negedge clk); dp_last_done = 1;
        @(negedge clk); dp_last_done = 0;
        chk("R1 last_block dropped", {63'd0, last_block}, 0);
        chk("R11 irq on done", {63'd0, irq}, 1);
        rd(6'd6, d);
        chk("R1 done bit", d, 64'h01);
        clear_status();
        @(negedge clk); dp_last_done = 1;
        @(negedge clk); dp_last_done = 0;
        rd(6'd6, d);
        chk("R1 done without go ignored", d, 0);
        chk("R11 irq low", {63'd0, irq}, 0);
    endtask

    task automatic t_keys();
        logic [63:0] d;
        wr(6'd5, 64'd16);
        rd(6'd5, d);
        chk("R6 ksize readback", d, 16);
        wr(6'd2, 64'hAAAA_0000_1111_2222);
        chk("R4 key1", key1_o, 64'hAAAA_0000_1111_2222);
        chk("R4 key3 mirror", key3_o, 64'hAAAA_0000_1111_2222);
        wr(6'd5, 64'd24);
        wr(6'd3, 64'hBBBB);
        wr(6'd4, 64'hCCCC);
        chk("R5 key2", key2_o, 64'hBBBB);
        chk("R5 key3 override", key3_o, 64'hCCCC);
        chk("R5 key1 kept", key1_o, 64'hAAAA_0000_1111_2222);
        wr(6'd2, 64'hDDDD);
        chk("R4 key3 remirror", key3_o, 64'hDDDD);
        rd(6'd3, d);
        chk("R7 key2 read zero", d, 0);
        rd(6'd6, d);
        chk("R7 key read error", d, 64'h08);
        clear_status();
        rd(6'd7, d);
        rd(6'd6, d);
        chk("R7 unmapped read error", d, 64'h08);
        clear_status();
    endtask

    task automatic t_single();
        wr(6'd5, 64'd8);
        wr(6'd2, 64'hEEEE);
        wr(6'd3, 64'hF0F0);
        wr(6'd4, 64'h1234);
        chk("R6 key2 ignored", key2_o, 64'hBBBB);
        chk("R6 key3 ignored", key3_o, 64'hEEEE);
        chk("R6 key1 loaded", key1_o, 64'hEEEE);
        wr(6'd5, 64'd16);
    endtask

    task automatic t_iv();
        logic [63:0] d;
        wr(6'd1, 64'h0123_4567_89AB_CDEF);
        rd(6'd1, d);
        chk("R2 iv readback", d, 64'h0123_4567_89AB_CDEF);
        @(negedge clk); dp_iv_wr = 1; dp_iv_word = 64'h5555_AAAA;
        @(negedge clk); dp_iv_wr = 0;
        chk("R2 iv_o datapath update", iv_o, 64'h5555_AAAA);
        rd(6'd1, d);
        chk("R2 iv readback update", d, 64'h5555_AAAA);
        dp_busy = 1;
        rd(6'd1, d);
        dp_busy = 0;
        chk("R3 busy read zero", d, 0);
        chk("R3 iv unchanged", iv_o, 64'h5555_AAAA);
        rd(6'd6, d);
        chk("R3 busy error bit", d, 64'h10);
        clear_status();
    endtask

    task automatic t_fifo();
        logic [63:0] d;
        wr(6'd32, 64'h100);
        wr(6'd45, 64'h101);
        wr(6'd63, 64'h102);
        chk("R8 in_level 3", {60'd0, in_level}, 3);
        chk("R8 head first", dp_in_word, 64'h100);
        @(negedge clk); dp_in_pop = 1;
        @(negedge clk); dp_in_pop = 0;
        chk("R8 head second", dp_in_word, 64'h101);
        for (int i = 0; i < 6; i++) wr(6'd40, 64'h200 + 64'(i));
        chk("R9 full level", {60'd0, in_level}, 8);
        wr(6'd33, 64'h999);
        chk("R9 level held", {60'd0, in_level}, 8);
        rd(6'd6, d);
        chk("R9 overflow bit", d, 64'h02);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); dp_in_pop = 1;
        end
        @(negedge clk); dp_in_pop = 0;
        chk("R9 drained", {60'd0, in_level}, 0);
        @(negedge clk); dp_out_push = 1; dp_out_word = 64'hA1;
        @(negedge clk); dp_out_word = 64'hA2;
        @(negedge clk); dp_out_push = 0;
        chk("R8 out_level", {60'd0, out_level}, 2);
        rd(6'd33, d);
        chk("R8 pop first", d, 64'hA1);
        rd(6'd60, d);
        chk("R8 pop second", d, 64'hA2);
        rd(6'd48, d);
        chk("R10 underflow zero", d, 0);
        rd(6'd6, d);
        chk("R10 underflow bit", d, 64'h06);
        wr(6'd6, 64'h02);
        rd(6'd6, d);
        chk("R11 selective clear", d, 64'h04);
        chk("R11 irq still set", {63'd0, irq}, 1);
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_go_done();
        t_keys();
        t_single();
        t_iv();
        t_fifo();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule